// File: doc/BRIEF.md
# Static LCD Three-and-a-Half Digit Segment Driver

This block turns a latched three-and-a-half digit reading into the drive lines of a statically driven liquid crystal display. It produces a slow square-wave backplane and, for each segment, a line that copies the backplane when the segment is dark and carries its inverse when the segment is lit. The voltage across every segment therefore averages to zero. The three lower digits are full seven-segment digits. The thousands position has one line that lights the two segments forming a "1". A further line drives the minus sign.

A conversion engine presents a new reading together with a sign flag and an overrange flag, and marks it with a one-cycle load strobe. The block captures the reading on that strobe and displays it until the next strobe. On overrange the three lower digits are blanked and the "1" stays lit. A lamp-test input turns every segment on and drives the lines with a steady level. All output lines are registered and change only on the clock edge where the backplane would toggle. With the default divider, that edge comes every 100 clocks.

Top module: `lcd7_static_drv`

## Requirements
- R1: `bp_out` is a 50% square wave that changes level exactly every HALF_PERIOD clocks while lamp test is off, and it is 0 after reset.
- R2: Outside lamp test, a dark segment line equals `bp_out` and a lit segment line equals its inverse.
- R3: Each lower digit decodes BCD 0-9 into segments a..g, mapped to bits [0]..[6] of its 7-bit group. The codes are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex, lit bits). Codes 10-15 light nothing.
- R4: The thousands line is lit when the latched thousands flag is 1. The minus line is lit when the latched negative flag is 1, and this also holds for a reading of zero.
- R5: When the latched overrange flag is 1, all three lower digits are dark and the thousands line is lit.
- R6: While `lamp_test` is 1, `bp_out` is held at 0 and every segment and sign line is held at 1, so the display reads -1888.
- R7: The reading, thousands, negative and overrange inputs are captured only in a cycle where `rd_load` is 1. Changes to them at any other time have no effect on the outputs.
- R8: Every output line changes only on a backplane toggle edge. A new reading or a lamp-test change takes effect at the next such edge.
- R9: After reset, and until the first load, all digits and signs are dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_load | input | 1 | One-cycle strobe that captures the reading |
| rd_bcd | input | 12 | BCD digits: units [3:0], tens [7:4], hundreds [11:8] |
| rd_thousand | input | 1 | Thousands digit is 1 |
| rd_negative | input | 1 | Reading is negative |
| rd_overrange | input | 1 | Reading is out of range |
| lamp_test | input | 1 | Light every segment with a steady level |
| bp_out | output | 1 | Backplane square wave |
| seg_digits | output | 21 | Segment lines: units [6:0], tens [13:7], hundreds [20:14], with a at the low bit |
| seg_thousand | output | 1 | Shared line for the thousands "1" |
| seg_minus | output | 1 | Minus-sign line |

## Verification
A load strobe and a backplane toggle can fall on the same clock edge. At such an edge the outputs must show the previous reading, and the new one must appear one toggle later. The bench does not align its loads with the backplane. It waits past at least one full toggle period before it compares, and it checks each reading in both backplane phases. Lamp test and a toggle edge meet in the same way. The bench raises and drops lamp test at arbitrary cycles and checks that the outputs switch mode only at a toggle. A checker assertion limits any change of the output lines to a toggle edge.

// File: rtl/lcd7_pkg.sv
// Package: shared constants and the BCD to seven-segment decode function.
// Assumes segment a sits in bit 0 and segment g in bit 6.
package lcd7_pkg;

    localparam int SEG_W = 7;
    localparam int BCD_W = 4;

    // Decode one BCD code into a lit-segment mask; codes above 9 light nothing.
    function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [BCD_W-1:0] code);
        logic [SEG_W-1:0] m;
        case (code)
            4'd0:    m = 7'h3F;
            4'd1:    m = 7'h06;
            4'd2:    m = 7'h5B;
            4'd3:    m = 7'h4F;
            4'd4:    m = 7'h66;
            4'd5:    m = 7'h6D;
            4'd6:    m = 7'h7D;
            4'd7:    m = 7'h07;
            4'd8:    m = 7'h7F;
            4'd9:    m = 7'h6F;
            default: m = 7'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lcd7_reading_latch.sv
// Reading latch: captures digits and flags on a single-cycle load strobe.
// Assumes the strobe marks a complete, settled reading. The reset value is
// an all-blank display (BCD code 15 in every digit, flags clear).
module lcd7_reading_latch
    import lcd7_pkg::*;
#(
    parameter int LOW_DIGITS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [LOW_DIGITS*BCD_W-1:0]   bcd_i,
    input  logic                          thou_i,
    input  logic                          neg_i,
    input  logic                          ovr_i,
    output logic [LOW_DIGITS*BCD_W-1:0]   bcd_q,
    output logic                          thou_q,
    output logic                          neg_q,
    output logic                          ovr_q
);

    // Hold the displayed reading; replace it only when the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcd_q  <= '1;
            thou_q <= 1'b0;
            neg_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (load_i) begin
            bcd_q  <= bcd_i;
            thou_q <= thou_i;
            neg_q  <= neg_i;
            ovr_q  <= ovr_i;
        end
    end

endmodule

// File: rtl/lcd7_bp_divider.sv
// Backplane divider: counts HALF_PERIOD clocks, then pulses tick_o and flips
// the phase. Assumes HALF_PERIOD >= 2. The counter restarts on synchronous reset.
module lcd7_bp_divider #(
    parameter int HALF_PERIOD = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o,
    output logic phase_o
);

    localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;

    assign tick_o  = (cnt_q == LAST);
    assign phase_o = phase_q;

    // Count clocks inside one half period and wrap on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // Flip the backplane phase once per half period.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= 1'b0;
        else if (tick_o) phase_q <= ~phase_q;
    end

endmodule

// File: rtl/lcd7_digit_decode.sv
// Digit decode: one seven-segment decoder per lower digit, with a common
// blank input that darkens all of them. Purely combinational.
module lcd7_digit_decode
    import lcd7_pkg::*;
#(
    parameter int LOW_DIGITS = 3
) (
    input  logic [LOW_DIGITS*BCD_W-1:0] bcd_i,
    input  logic                        blank_i,
    output logic [LOW_DIGITS*SEG_W-1:0] lit_o
);

    for (genvar d = 0; d < LOW_DIGITS; d++) begin : g_digit
        // Map this digit's code to its lit mask, or dark when blanked.
        always_comb begin
            lit_o[d*SEG_W +: SEG_W] = blank_i ? '0
                                    : bcd_to_seg(bcd_i[d*BCD_W +: BCD_W]);
        end
    end

endmodule

// File: rtl/lcd7_static_drv.sv
// Static LCD driver top: latch -> decode -> output stage, timed by the divider.
// Every output is a register loaded only on the divider tick. Normal mode
// drives each line as the backplane XOR the lit state. Lamp test drives a
// steady level: backplane 0, all segment lines 1.
module lcd7_static_drv
    import lcd7_pkg::*;
#(
    parameter int HALF_PERIOD = 100,
    parameter int LOW_DIGITS  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_load,
    input  logic [LOW_DIGITS*BCD_W-1:0] rd_bcd,
    input  logic                        rd_thousand,
    input  logic                        rd_negative,
    input  logic                        rd_overrange,
    input  logic                        lamp_test,
    output logic                        bp_out,
    output logic [LOW_DIGITS*SEG_W-1:0] seg_digits,
    output logic                        seg_thousand,
    output logic                        seg_minus
);

    localparam int LOW_W = LOW_DIGITS * SEG_W;
    localparam int ALL_W = LOW_W + 2;

    logic [LOW_DIGITS*BCD_W-1:0] bcd_q;
    logic                        thou_q, neg_q, ovr_q;
    logic [LOW_W-1:0]            lit_low;
    logic                        lit_one;
    logic                        tick, phase;
    logic [ALL_W-1:0]            lit_all;
    logic [ALL_W-1:0]            seg_q;
    logic                        bp_q;

    lcd7_reading_latch #(.LOW_DIGITS(LOW_DIGITS)) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rd_load),
        .bcd_i  (rd_bcd),
        .thou_i (rd_thousand),
        .neg_i  (rd_negative),
        .ovr_i  (rd_overrange),
        .bcd_q  (bcd_q),
        .thou_q (thou_q),
        .neg_q  (neg_q),
        .ovr_q  (ovr_q)
    );

    lcd7_digit_decode #(.LOW_DIGITS(LOW_DIGITS)) decode_i (
        .bcd_i   (bcd_q),
        .blank_i (ovr_q),
        .lit_o   (lit_low)
    );

    lcd7_bp_divider #(.HALF_PERIOD(HALF_PERIOD)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_o  (tick),
        .phase_o (phase)
    );

    // Gather the lit state of every line: minus, thousands, lower digits.
    always_comb begin
        lit_one = thou_q | ovr_q;
        lit_all = {neg_q, lit_one, lit_low};
    end

    // Load all lines on the tick, using the backplane level that follows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_q  <= 1'b0;
            seg_q <= '0;
        end else if (tick) begin
            if (lamp_test) begin
                bp_q  <= 1'b0;
                seg_q <= '1;
            end else begin
                bp_q  <= ~phase;
                seg_q <= lit_all ^ {ALL_W{~phase}};
            end
        end
    end

    assign bp_out       = bp_q;
    assign seg_digits   = seg_q[LOW_W-1:0];
    assign seg_thousand = seg_q[LOW_W];
    assign seg_minus    = seg_q[LOW_W+1];

endmodule

// File: rtl/lcd7_static_drv_chk.sv
// Checker for lcd7_static_drv: timing of output changes, lamp-test level,
// overrange blanking and latch hold. Attached by the bind at the end of this file.
module lcd7_static_drv_chk
    import lcd7_pkg::*;
#(
    parameter int HALF_PERIOD = 100,
    parameter int LOW_DIGITS  = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rd_load,
    input logic                        lamp_test,
    input logic                        bp_out,
    input logic [LOW_DIGITS*SEG_W-1:0] seg_digits,
    input logic                        seg_thousand,
    input logic                        seg_minus,
    input logic [LOW_DIGITS*BCD_W-1:0] bcd_q,
    input logic                        thou_q,
    input logic                        neg_q,
    input logic                        ovr_q,
    input logic [LOW_DIGITS*SEG_W-1:0] lit_low,
    input logic                        lit_one
);

    localparam int OUT_W = LOW_DIGITS * SEG_W + 3;

    logic [OUT_W-1:0] out_now, out_prev;
    logic             out_changed;
    int unsigned      gap_q;

    assign out_now     = {bp_out, seg_minus, seg_thousand, seg_digits};
    assign out_changed = (out_now != out_prev);

    // Remember the outputs of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_prev <= '0;
        else        out_prev <= out_now;
    end

    // Count the quiet cycles since the last output change, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                               gap_q <= 0;
        else if (out_changed)                     gap_q <= 0;
        else if (gap_q < HALF_PERIOD)             gap_q <= gap_q + 1;
    end

    // R8: outputs change no sooner than one backplane half period apart.
    a_r8_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        out_changed |-> (gap_q >= HALF_PERIOD - 1));

    // R6: a change made while lamp test was high lands on the steady all-on level.
    a_r6_lamp_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (out_changed && $past(lamp_test)) |->
        (!bp_out && seg_minus && seg_thousand && (&seg_digits)));

    // R5: overrange darkens the lower digits and keeps the thousands line lit.
    a_r5_ovr_blank: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> ((lit_low == '0) && lit_one));

    // R7: the latched reading holds whenever no strobe was seen.
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_load) |-> $stable({bcd_q, thou_q, neg_q, ovr_q}));

endmodule

bind lcd7_static_drv lcd7_static_drv_chk #(
    .HALF_PERIOD (HALF_PERIOD),
    .LOW_DIGITS  (LOW_DIGITS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_load      (rd_load),
    .lamp_test    (lamp_test),
    .bp_out       (bp_out),
    .seg_digits   (seg_digits),
    .seg_thousand (seg_thousand),
    .seg_minus    (seg_minus),
    .bcd_q        (bcd_q),
    .thou_q       (thou_q),
    .neg_q        (neg_q),
    .ovr_q        (ovr_q),
    .lit_low      (lit_low),
    .lit_one      (lit_one)
);

// File: tb/lcd7_static_drv_tb_top.sv
// Scoreboard bench: driver tasks push expected lit patterns into a queue,
// and a monitor pops and compares them against the output lines.
module lcd7_static_drv_tb_top;

    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_load = 1'b0;
    logic [11:0] rd_bcd = '0;
    logic        rd_thousand = 1'b0;
    logic        rd_negative = 1'b0;
    logic        rd_overrange = 1'b0;
    logic        lamp_test = 1'b0;
    logic        bp_out;
    logic [20:0] seg_digits;
    logic        seg_thousand, seg_minus;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [23:0] q_exp[$];
    string       q_req[$];

    always #5 clk = ~clk;

    lcd7_static_drv #(.HALF_PERIOD(HALF), .LOW_DIGITS(3)) dut_i (
        .clk, .rst_n, .rd_load, .rd_bcd, .rd_thousand, .rd_negative,
        .rd_overrange, .lamp_test, .bp_out, .seg_digits, .seg_thousand, .seg_minus
    );

    // Bench-side cycle count since reset release; ticks fall where it is a multiple of HALF.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [6:0] ref_seg(input logic [3:0] c);
        case (c)
            0: return 7'b0111111;  1: return 7'b0000110;
            2: return 7'b1011011;  3: return 7'b1001111;
            4: return 7'b1100110;  5: return 7'b1101101;
            6: return 7'b1111101;  7: return 7'b0000111;
            8: return 7'b1111111;  9: return 7'b1101111;
            default: return 7'b0;
        endcase
    endfunction

    // Item bit 23 = lamp mode; bits [22:0] = {minus, one, hundreds, tens, units} lit.
    function automatic logic [23:0] ref_item(input logic [11:0] b, input logic th,
                                             input logic ng, input logic ov);
        logic [20:0] low;
        low = ov ? 21'b0 : {ref_seg(b[11:8]), ref_seg(b[7:4]), ref_seg(b[3:0])};
        return {1'b0, ng, th | ov, low};
    endfunction

    // Monitor: pop one expected item and compare it with the lines.
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [23:0] e;
            string       r;
            logic [22:0] got, want;
            logic        bp_want;
            e = q_exp.pop_front();
            r = q_req.pop_front();
            got = {seg_minus, seg_thousand, seg_digits};
            if (e[23]) begin
                want = '1;
                bp_want = 1'b0;
            end else begin
                want = e[22:0] ^ {23{bp_out}};
                bp_want = bp_out;
            end
            n_vec++;
            if (got !== want || bp_out !== bp_want) begin
                n_bad++;
                $display("FAIL %s: actual bp=%b seg=%h, expected bp=%b seg=%h",
                         r, bp_out, got, bp_want, want);
            end
        end
    end

    // Wait past at least one tick, then to 2 clocks after a tick.
    task automatic settle();
        repeat (HALF) @(negedge clk);
        while ((cyc % HALF) != 2) @(negedge clk);
    endtask

    // Push an item in both backplane phases.
    task automatic expect_both(input logic [23:0] e, input string r);
        q_exp.push_back(e); q_req.push_back(r);
        repeat (HALF) @(negedge clk);
        q_exp.push_back(e); q_req.push_back(r);
        @(negedge clk);
    endtask

    task automatic show(input logic [11:0] b, input logic th, input logic ng,
                        input logic ov, input string r);
        @(negedge clk);
        rd_bcd = b; rd_thousand = th; rd_negative = ng; rd_overrange = ov;
        rd_load = 1'b1;
        @(negedge clk);
        rd_load = 1'b0;
        settle();
        expect_both(ref_item(b, th, ng, ov), r);
    endtask

    // Direct check of the backplane half period.
    task automatic measure_bp();
        logic last;
        int   n;
        @(negedge clk);
        last = bp_out;
        while (bp_out === last) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            last = bp_out;
            n = 0;
            while (bp_out === last && n < 4 * HALF) begin
                @(negedge clk);
                n++;
            end
            n_vec++;
            if (n != HALF) begin
                n_bad++;
                $display("FAIL R1: actual half period %0d, expected %0d", n, HALF);
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state: backplane low, all lines low.
        n_vec++;
        if (bp_out !== 1'b0 || {seg_minus, seg_thousand, seg_digits} !== 23'b0) begin
            n_bad++;
            $display("FAIL R9: actual bp=%b seg=%h, expected bp=0 seg=0",
                     bp_out, {seg_minus, seg_thousand, seg_digits});
        end
        settle();
        expect_both(24'h0, "R9 blank before load");
        measure_bp();

        // R3: every decimal code in every position, plus R2 phase relation.
        for (int v = 0; v < 10; v++)
            show({4'(v), 4'((v + 3) % 10), 4'((v + 7) % 10)}, 1'b0, 1'b0, 1'b0, "R3 R2 digits");
        show(12'hABF, 1'b0, 1'b0, 1'b0, "R3 codes above 9 blank");
        show(12'hC5E, 1'b1, 1'b0, 1'b0, "R3 mixed codes");

        // R4: thousands and sign, including negative zero.
        show(12'h999, 1'b1, 1'b0, 1'b0, "R4 thousands lit");
        show(12'h000, 1'b0, 1'b1, 1'b0, "R4 minus at zero");
        show(12'h123, 1'b1, 1'b1, 1'b0, "R4 negative 1123");

        // R5: overrange blanks lower digits, both signs.
        show(12'h456, 1'b0, 1'b0, 1'b1, "R5 overrange positive");
        show(12'h888, 1'b0, 1'b1, 1'b1, "R5 overrange negative");

        // R7: input changes without a strobe have no effect.
        show(12'h271, 1'b0, 1'b1, 1'b0, "R7 base reading");
        @(negedge clk);
        rd_bcd = 12'h999; rd_thousand = 1'b1; rd_negative = 1'b0; rd_overrange = 1'b1;
        settle();
        expect_both(ref_item(12'h271, 1'b0, 1'b1, 1'b0), "R7 no strobe ignored");

        // R6: lamp test, raised at an arbitrary cycle, steady all-on.
        repeat (3) @(negedge clk);
        lamp_test = 1'b1;
        settle();
        expect_both(24'h800000, "R6 lamp test");
        q_exp.push_back(24'h800000); q_req.push_back("R6 lamp steady");
        repeat (2) @(negedge clk);
        lamp_test = 1'b0;

        // R8: after lamp drops, normal drive returns at the next tick.
        settle();
        expect_both(ref_item(12'h271, 1'b0, 1'b1, 1'b0), "R8 resume after lamp");

        // R8: a strobe placed exactly on a tick edge shows after the following tick.
        while ((cyc % HALF) != HALF - 1) @(negedge clk);
        rd_bcd = 12'h305; rd_thousand = 1'b0; rd_negative = 1'b0; rd_overrange = 1'b0;
        rd_load = 1'b1;
        @(negedge clk);
        rd_load = 1'b0;
        // Still the old reading right after that tick.
        q_exp.push_back(ref_item(12'h271, 1'b0, 1'b1, 1'b0));
        q_req.push_back("R8 old reading on strobe tick");
        @(negedge clk);
        settle();
        expect_both(ref_item(12'h305, 1'b0, 1'b0, 1'b0), "R8 new reading next tick");

        measure_bp();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule